// File: doc/BRIEF.md
# Power-Good Reset Supervisor

This block supervises one regulated supply rail and produces an active-low reset for the logic the rail powers. Two analog comparators sit outside the block. One raises a flag while the rail sits above its upper threshold (94 % of nominal). The other raises a flag while the rail sits below its lower threshold (90 % of nominal). The block qualifies these flags over time. Power-good is declared only after the rail has stayed high for a long entry window. It is withdrawn only after the rail has stayed low for a short exit window. A glitch on either flag restarts the window that is running.

The reset pin is modelled as an open-drain driver. The output-enable is 1 while the reset is pulled low and 0 while the pin is released to the external pull-up. Both windows are counted in clock cycles. A common scale factor stretches them together. The exit window is never shorter than a configured floor, which gives immunity to transient-induced false resets. Disabling the rail, or applying reset, removes power-good in the same cycle.

Top module: `pgSupervisor`

## Requirements
- R1: After reset is applied (rstN low), pwrGood is 0 and porOe is 1.
- R2: With railEn high and pwrGood 0, pwrGood becomes 1 right after the clock edge on which aboveHi has been sampled high for the ENTRY_CYC*DELAY_SCALE-th consecutive time, and not before.
- R3: If aboveHi is sampled low before the entry window completes, the entry count restarts from zero, and a full window of consecutive high samples is needed again.
- R4: With pwrGood 1, pwrGood becomes 0 right after the edge on which belowLo has been sampled high for the exit-window-th consecutive time.
- R5: If belowLo is sampled low before the exit window completes, pwrGood stays 1 and the exit count restarts from zero.
- R6: The exit window is max(EXIT_CYC*DELAY_SCALE, MIN_EXIT_CYC). A smaller scaled setting is clamped to the floor.
- R7: DELAY_SCALE multiplies both the entry and the exit settings.
- R8: While railEn is 0, pwrGood is 0 and porOe is 1 in the same cycle, and any count in progress is discarded. After re-enable, a full entry window is needed.
- R9: Hysteresis. While pwrGood is 1, aboveHi has no effect. While pwrGood is 0, belowLo has no effect.
- R10: porOe is always the inverse of pwrGood: the reset is driven low exactly when power is not good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counting is in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| railEn | input | 1 | Enable of the supervised rail channel |
| aboveHi | input | 1 | Comparator flag: rail above the upper threshold |
| belowLo | input | 1 | Comparator flag: rail below the lower threshold |
| pwrGood | output | 1 | Qualified power-good status |
| porOe | output | 1 | Open-drain enable: 1 drives reset low, 0 releases it |

## Verification
The bench builds two instances.

The first instance uses an entry setting of 12 cycles, an exit setting of 2, a floor of 4 and a scale of 1. With these values the exit clamp is active, and every window edge can be reached in a few dozen cycles. The bench can therefore show the unclamped value (2) being ignored in favour of the floor (4).

The second instance uses an entry setting of 6, an exit setting of 3, a floor of 4 and a scale of 2. Its effective windows are 12 and 6. This shows scaling acting on both windows, with the exit window above the floor, so the clamp stays out of the way.

// File: rtl/pgSupervisorPkg.sv
package pgSupervisorPkg;

  // Strobes from control to the window counter
  typedef struct packed {
    logic clr;   // restart the window count
    logic inc;   // one more qualifying sample
  } pgStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgWindowCounter.sv
module pgWindowCounter
  import pgSupervisorPkg::*;
#(
  parameter int ENTRY_LIM = 12,
  parameter int EXIT_LIM  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      exitPhase,
  input  pgStrobe_t strobe,
  output logic      lastSample
);
  localparam int CNT_MAX = maxOf(ENTRY_LIM, EXIT_LIM);
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] lastIdx;

  // One counter serves both windows; only one can be running at a time
  assign lastIdx    = exitPhase ? CNT_W'(EXIT_LIM - 1) : CNT_W'(ENTRY_LIM - 1);
  assign lastSample = (winCnt == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           winCnt <= '0;
    else if (strobe.clr) winCnt <= '0;
    else if (strobe.inc) winCnt <= winCnt + 1'b1;
  end

endmodule

// File: rtl/pgControl.sv
module pgControl
  import pgSupervisorPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      railEn,
  input  logic      aboveHi,
  input  logic      belowLo,
  input  logic      lastSample,
  output logic      goodQ,
  output pgStrobe_t strobe
);
  logic goodNext;

  always_comb begin
    strobe   = '0;
    goodNext = goodQ;
    if (!railEn) begin
      strobe.clr = 1'b1;
      goodNext   = 1'b0;
    end else if (!goodQ) begin
      // Entry qualification: only the upper-threshold flag matters here
      if (!aboveHi) begin
        strobe.clr = 1'b1;
      end else if (lastSample) begin
        strobe.clr = 1'b1;
        goodNext   = 1'b1;
      end else begin
        strobe.inc = 1'b1;
      end
    end else begin
      // Exit qualification: only the lower-threshold flag matters here
      if (!belowLo) begin
        strobe.clr = 1'b1;
      end else if (lastSample) begin
        strobe.clr = 1'b1;
        goodNext   = 1'b0;
      end else begin
        strobe.inc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) goodQ <= 1'b0;
    else       goodQ <= goodNext;
  end

endmodule

// File: rtl/pgSupervisor.sv
module pgSupervisor
  import pgSupervisorPkg::*;
#(
  parameter int ENTRY_CYC    = 20_000_000,
  parameter int EXIT_CYC     = 2_500,
  parameter int MIN_EXIT_CYC = 1_000,
  parameter int DELAY_SCALE  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic railEn,
  input  logic aboveHi,
  input  logic belowLo,
  output logic pwrGood,
  output logic porOe
);
  localparam int ENTRY_EFF   = ENTRY_CYC * DELAY_SCALE;
  localparam int EXIT_SCALED = EXIT_CYC * DELAY_SCALE;
  localparam int EXIT_EFF    = maxOf(EXIT_SCALED, MIN_EXIT_CYC);

  logic      goodQ;
  logic      lastSample;
  pgStrobe_t strobe;

  pgControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .railEn     (railEn),
    .aboveHi    (aboveHi),
    .belowLo    (belowLo),
    .lastSample (lastSample),
    .goodQ      (goodQ),
    .strobe     (strobe)
  );

  pgWindowCounter #(
    .ENTRY_LIM (ENTRY_EFF),
    .EXIT_LIM  (EXIT_EFF)
  ) u_win (
    .clk        (clk),
    .rstN       (rstN),
    .exitPhase  (goodQ),
    .strobe     (strobe),
    .lastSample (lastSample)
  );

  // Disable removes power-good without waiting for an edge
  assign pwrGood = goodQ & railEn;
  assign porOe   = ~pwrGood;

endmodule

// File: rtl/pgSupervisorChk.sv
module pgSupervisorChk #(
  parameter int ENTRY_EFF = 12,
  parameter int EXIT_EFF  = 4
) (
  input logic clk,
  input logic rstN,
  input logic railEn,
  input logic aboveHi,
  input logic belowLo,
  input logic pwrGood,
  input logic porOe
);
  int hiRun;
  int loRun;

  // Independent run-length trackers for the qualifying windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun <= 0;
      loRun <= 0;
    end else begin
      hiRun <= (railEn && !pwrGood && aboveHi) ? hiRun + 1 : 0;
      loRun <= (railEn &&  pwrGood && belowLo) ? loRun + 1 : 0;
    end
  end

  assert_entry_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrGood) |-> (hiRun == ENTRY_EFF));

  assert_entry_needs_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrGood) |-> $past(aboveHi));

  assert_exit_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pwrGood) && railEn && $past(railEn)) |-> (loRun == EXIT_EFF));

  assert_hold_good_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && !belowLo) |=> (pwrGood || !railEn));

  assert_disable_forces_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    !railEn |-> (!pwrGood && porOe));

endmodule

bind pgSupervisor pgSupervisorChk #(
  .ENTRY_EFF (ENTRY_EFF),
  .EXIT_EFF  (EXIT_EFF)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .railEn  (railEn),
  .aboveHi (aboveHi),
  .belowLo (belowLo),
  .pwrGood (pwrGood),
  .porOe   (porOe)
);

// File: tb/tb_pgSupervisor.sv
`timescale 1ns/1ps
module tb_pgSupervisor;
  localparam int ENT  = 12;  // first instance entry window
  localparam int EXT  = 4;   // first instance exit window (clamped from 2)
  localparam int ENT2 = 12;  // scaled instance: 6*2
  localparam int EXT2 = 6;   // scaled instance: 3*2

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic railEn = 1'b0;
  logic railEn2 = 1'b0;
  logic aboveHi = 1'b0;
  logic belowLo = 1'b0;
  logic pwrGood, porOe, pwrGood2, porOe2;
  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pgSupervisor #(.ENTRY_CYC(12), .EXIT_CYC(2), .MIN_EXIT_CYC(4), .DELAY_SCALE(1)) dut (
    .clk(clk), .rstN(rstN), .railEn(railEn), .aboveHi(aboveHi), .belowLo(belowLo),
    .pwrGood(pwrGood), .porOe(porOe));

  pgSupervisor #(.ENTRY_CYC(6), .EXIT_CYC(3), .MIN_EXIT_CYC(4), .DELAY_SCALE(2)) dutScaled (
    .clk(clk), .rstN(rstN), .railEn(railEn2), .aboveHi(aboveHi), .belowLo(belowLo),
    .pwrGood(pwrGood2), .porOe(porOe2));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Return the first instance to the not-good state with idle flags
  task automatic settle();
    aboveHi = 1'b0; belowLo = 1'b0; railEn = 1'b0;
    tick(1);
    railEn = 1'b1;
    tick(1);
  endtask

  task automatic goGood();
    aboveHi = 1'b1;
    tick(ENT);
    aboveHi = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 pwrGood in reset", pwrGood, 1'b0);
    chk("R1 porOe in reset", porOe, 1'b1);
    rstN = 1'b1;
    railEn = 1'b1;
    aboveHi = 1'b1;
    tick(3);
    rstN = 1'b0;
    #1;
    chk("R1 pwrGood after reset", pwrGood, 1'b0);
    chk("R10 porOe after reset", porOe, 1'b1);
    tick(1);
    rstN = 1'b1;
  endtask

  task automatic testEntry();
    settle();
    aboveHi = 1'b1;
    tick(ENT - 1);
    chk("R2 not good one sample early", pwrGood, 1'b0);
    chk("R10 reset driven while not good", porOe, 1'b1);
    tick(1);
    chk("R2 good after full entry window", pwrGood, 1'b1);
    chk("R10 reset released while good", porOe, 1'b0);
  endtask

  task automatic testEntryGlitch();
    settle();
    aboveHi = 1'b1;
    tick(ENT - 2);
    aboveHi = 1'b0;
    tick(1);
    aboveHi = 1'b1;
    tick(ENT - 1);
    chk("R3 glitch restarts entry count", pwrGood, 1'b0);
    tick(1);
    chk("R3 good after restarted window", pwrGood, 1'b1);
  endtask

  task automatic testExitClamp();
    settle();
    goGood();
    belowLo = 1'b1;
    tick(2);
    chk("R6 unclamped exit value not used", pwrGood, 1'b1);
    tick(EXT - 3);
    chk("R4 still good one sample early", pwrGood, 1'b1);
    tick(1);
    chk("R4 R6 dropped after clamped exit window", pwrGood, 1'b0);
    chk("R10 reset driven after exit", porOe, 1'b1);
  endtask

  task automatic testExitGlitch();
    settle();
    goGood();
    belowLo = 1'b1;
    tick(EXT - 1);
    belowLo = 1'b0;
    tick(1);
    chk("R5 short dip keeps good", pwrGood, 1'b1);
    belowLo = 1'b1;
    tick(EXT - 1);
    chk("R5 exit count restarted", pwrGood, 1'b1);
    tick(1);
    chk("R5 dropped after full window", pwrGood, 1'b0);
  endtask

  task automatic testHysteresis();
    settle();
    belowLo = 1'b1;
    aboveHi = 1'b1;
    tick(ENT);
    chk("R9 belowLo ignored while not good", pwrGood, 1'b1);
    aboveHi = 1'b0;
    belowLo = 1'b0;
    tick(3 * ENT);
    chk("R9 aboveHi low ignored while good", pwrGood, 1'b1);
  endtask

  task automatic testDisable();
    settle();
    goGood();
    aboveHi = 1'b1;
    railEn = 1'b0;
    #1;
    chk("R8 disable drops good at once", pwrGood, 1'b0);
    chk("R8 disable drives reset at once", porOe, 1'b1);
    tick(1);
    railEn = 1'b1;
    tick(ENT - 1);
    chk("R8 re-enable needs full window", pwrGood, 1'b0);
    tick(1);
    chk("R8 good after window on re-enable", pwrGood, 1'b1);
    settle();
    aboveHi = 1'b1;
    tick(ENT - 1);
    railEn = 1'b0;
    tick(1);
    railEn = 1'b1;
    tick(ENT - 1);
    chk("R8 disable discards partial count", pwrGood, 1'b0);
    tick(1);
    chk("R8 good after fresh count", pwrGood, 1'b1);
  endtask

  task automatic testScaled();
    aboveHi = 1'b0; belowLo = 1'b0; railEn2 = 1'b0;
    tick(1);
    chk("R8 scaled instance off while disabled", pwrGood2, 1'b0);
    railEn2 = 1'b1;
    aboveHi = 1'b1;
    tick(ENT2 - 1);
    chk("R7 scaled entry not early", pwrGood2, 1'b0);
    tick(1);
    chk("R7 scaled entry window", pwrGood2, 1'b1);
    aboveHi = 1'b0;
    belowLo = 1'b1;
    tick(EXT2 - 1);
    chk("R7 scaled exit not early", pwrGood2, 1'b1);
    tick(1);
    chk("R7 scaled exit window", pwrGood2, 1'b0);
    chk("R10 scaled reset driven", porOe2, 1'b1);
    belowLo = 1'b0;
  endtask

  initial begin
    tick(2);
    testReset();
    testEntry();
    testEntryGlitch();
    testExitClamp();
    testExitGlitch();
    testHysteresis();
    testDisable();
    testScaled();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule